// File: doc/BRIEF.md
# Write Leveling Tap Scanner

This block is a hardware sequencer that characterises the write-leveling window of every byte lane of a DDR memory PHY. After a start request it turns write leveling on and lets the memory settle. It then visits each lane in turn. For each lane it clears the lane's DQ and DQS output delays and preloads the DQS delay to a configured starting tap. It then walks DQ and DQS forward together, one tap per step, and records at each step whether the memory returned any nonzero bit.

The per-lane pass/fail bitmaps go into a small result array. Firmware or a later calibration stage reads that array through an address/data port to choose a final delay. The delay lines and the memory device are outside the block. The block only drives their control pulses and samples the returned data word.

Top module: `wl_tap_scan`

## Requirements
- R1: While reset is held and after its release, every control output (wl_en, lane_sel, dq_rst, dqs_rst, dq_inc, dqs_inc, lvl_strobe, busy, done) is 0, and every lane reads back an all-zero result.
- R2: A start seen while idle raises wl_en and busy. Exactly SETTLE (default 100) cycles with wl_en high pass before the first delay reset pulse.
- R3: Lanes are visited in order 0, 1, …, LANES-1. While lane n is being worked on, lane_sel equals 1<<n. At all other times it is 0.
- R4: Each lane begins with one cycle in which dq_rst and dqs_rst pulse together. This is followed by exactly init_taps single-cycle dqs_inc pulses, with no dq_inc pulse, before the lane's first strobe. init_taps is captured when the scan is started.
- R5: Each lane takes MAX_TAPS steps. Each step is a one-cycle lvl_strobe pulse. The sample is taken SAMPLE_WAIT+1 cycles after the strobe cycle (default 11), that is, after 10 full wait cycles. The sample comes from data word LANES-1-n, bits [(LANES-1-n)*WORD_W +: WORD_W] of rd_data. The step's bit is 1 when that word is nonzero and 0 otherwise.
- R6: After every sample, dq_inc and dqs_inc pulse together for one cycle. At step t the DQ delay is therefore t taps and the DQS delay is init_taps+t taps.
- R7: With res_addr = n, res_data bit t holds the result of step t of lane n. The read path is combinational.
- R8: After the last step of the last lane, done is high for exactly one cycle. wl_en is low in that cycle, and busy is low from the next cycle on.
- R9: A start asserted while busy is ignored. The running scan is not restarted and does not recapture init_taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (accepted only when idle) |
| init_taps | input | TAP_W | Initial DQS tap count applied before each lane's sweep |
| rd_data | input | LANES*WORD_W | Returned data, one word per lane, lane n in word LANES-1-n |
| res_addr | input | LW | Lane index for result readout |
| wl_en | output | 1 | Write leveling enable |
| lane_sel | output | LANES | One-hot selected lane |
| dq_rst | output | 1 | DQ delay reset pulse |
| dqs_rst | output | 1 | DQS delay reset pulse |
| dq_inc | output | 1 | DQ delay increment pulse |
| dqs_inc | output | 1 | DQS delay increment pulse |
| lvl_strobe | output | 1 | Leveling strobe pulse |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | MAX_TAPS | Result bitmap of lane res_addr |

## Verification
Some internal faults show up only at the ports. A wrong lane or step counter writes the stored bit to the wrong position of the readback array. A shifted wait counter samples the data word while it is still absent, so a bit that should pass comes back 0. A bad preload count is visible at the very first strobe of a lane, because the stub's DQS tap position differs from init_taps. Sequencing faults are caught within the same lane or at the final done. These include lanes out of order, increments missing after a sample, or a restart on a busy start. They show up as lane_sel mismatches, the wrong number of reset pulses, or an extra done.

// File: rtl/wl_tap_scan.sv
module wl_tap_scan #(
  parameter int LANES       = 4,
  parameter int MAX_TAPS    = 16,
  parameter int WORD_W      = 8,
  parameter int TAP_W       = 6,
  parameter int SETTLE      = 100,
  parameter int SAMPLE_WAIT = 10,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [TAP_W-1:0]          init_taps,
  input  logic [LANES*WORD_W-1:0]   rd_data,
  input  logic [LW-1:0]             res_addr,
  output logic                      wl_en,
  output logic [LANES-1:0]          lane_sel,
  output logic                      dq_rst,
  output logic                      dqs_rst,
  output logic                      dq_inc,
  output logic                      dqs_inc,
  output logic                      lvl_strobe,
  output logic                      busy,
  output logic                      done,
  output logic [MAX_TAPS-1:0]       res_data
);
  localparam int SW = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1;
  localparam int CW = 16;
  localparam logic [CW-1:0] SETTLE_END = CW'(SETTLE - 1);
  localparam logic [CW-1:0] WAIT_END   = CW'(SAMPLE_WAIT - 1);
  localparam logic [SW-1:0] LAST_STEP  = SW'(MAX_TAPS - 1);
  localparam logic [LW-1:0] LAST_LANE  = LW'(LANES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETTLE, S_LRST, S_PRE, S_STRB, S_WAIT, S_SAMP, S_STEP, S_DONE
  } st_t;

  st_t                st;
  logic [CW-1:0]      cnt;
  logic [LW-1:0]      lane;
  logic [SW-1:0]      step;
  logic [TAP_W-1:0]   taps;
  logic [MAX_TAPS-1:0] res [LANES];

  wire [WORD_W-1:0] word = rd_data[(LANES - 1 - int'(lane))*WORD_W +: WORD_W];
  wire in_lane = st inside {S_LRST, S_PRE, S_STRB, S_WAIT, S_SAMP, S_STEP};

  assign busy       = (st != S_IDLE);
  assign wl_en      = busy && (st != S_DONE);
  assign done       = (st == S_DONE);
  assign lane_sel   = in_lane ? (LANES'(1) << lane) : '0;
  assign dq_rst     = (st == S_LRST);
  assign dqs_rst    = (st == S_LRST);
  assign dq_inc     = (st == S_STEP);
  assign dqs_inc    = (st == S_STEP) || (st == S_PRE);
  assign lvl_strobe = (st == S_STRB);
  assign res_data   = res[res_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      lane <= '0;
      step <= '0;
      taps <= '0;
      for (int i = 0; i < LANES; i++) res[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          taps <= init_taps;
          lane <= '0;
          cnt  <= '0;
          st   <= S_SETTLE;
        end
        S_SETTLE: if (cnt == SETTLE_END) st <= S_LRST;
                  else cnt <= cnt + 1'b1;
        S_LRST: begin
          cnt  <= '0;
          step <= '0;
          st   <= (taps == '0) ? S_STRB : S_PRE;
        end
        S_PRE: begin
          cnt <= cnt + 1'b1;
          if (cnt + 1'b1 == CW'(taps)) st <= S_STRB;
        end
        S_STRB: begin
          cnt <= '0;
          st  <= S_WAIT;
        end
        S_WAIT: if (cnt == WAIT_END) st <= S_SAMP;
                else cnt <= cnt + 1'b1;
        S_SAMP: begin
          res[lane][step] <= |word;
          st <= S_STEP;
        end
        S_STEP: if (step == LAST_STEP) begin
          if (lane == LAST_LANE) st <= S_DONE;
          else begin
            lane <= lane + 1'b1;
            st   <= S_LRST;
          end
        end else begin
          step <= step + 1'b1;
          st   <= S_STRB;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module wl_tap_scan_chk #(parameter int LANES = 4) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             wl_en,
  input logic [LANES-1:0] lane_sel,
  input logic             dq_rst,
  input logic             dq_inc,
  input logic             dqs_inc,
  input logic             lvl_strobe,
  input logic             busy,
  input logic             done
);
  assert_lane_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_sel));
  assert_lane_in_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sel != '0) |-> wl_en);
  assert_rst_needs_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_rst |-> (lane_sel != '0) && wl_en);
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_strobe |=> !lvl_strobe && !dq_inc);
  assert_inc_paired_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_inc |-> dqs_inc);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wl_en ##1 (!done && !busy));
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wl_en && !done) |=> busy);
endmodule

bind wl_tap_scan wl_tap_scan_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wl_en(wl_en), .lane_sel(lane_sel),
  .dq_rst(dq_rst), .dq_inc(dq_inc), .dqs_inc(dqs_inc), .lvl_strobe(lvl_strobe),
  .busy(busy), .done(done)
);

// File: tb/wl_tap_scan_test.sv
module wl_tap_scan_test;
  localparam int LANES = 4, TAPS = 16, W = 8;

  logic clk = 0, rst_n = 0, start = 0;
  logic [5:0] init_taps = '0;
  logic [LANES*W-1:0] rd_data = '0;
  logic [1:0] res_addr = '0;
  logic wl_en, dq_rst, dqs_rst, dq_inc, dqs_inc, lvl_strobe, busy, done;
  logic [LANES-1:0] lane_sel;
  logic [TAPS-1:0] res_data;

  wl_tap_scan uut (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  int run_init = 0, run_base = 0;
  int dq_tap = 0, dqs_tap = 0, step_no = 0, cur_lane = -1, exp_lane = 0;
  int settle_cnt = 0, rst_seen = 0, done_cnt = 0, since = 0;
  bit arm = 0, first_rst = 0;
  logic [W-1:0] pend = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit pass_at(input int lane, input int tap, input int base);
    return tap >= base + 3*lane && tap < base + 3*lane + 4;
  endfunction

  // behavioural delay-line / memory stub and sequence monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wl_en && !first_rst && !dq_rst) settle_cnt++;
      if (done) begin
        done_cnt++;
        chk(!wl_en, "R8 wl_en low during done", wl_en, 0);
      end
      if (dq_rst) begin
        chk(dqs_rst, "R4 paired reset", dqs_rst, 1);
        chk(lane_sel == LANES'(1 << exp_lane), "R3 lane order", lane_sel, 1 << exp_lane);
        cur_lane = exp_lane; exp_lane++; rst_seen++; first_rst = 1;
        dq_tap = 0; dqs_tap = 0; step_no = 0;
      end
      if (dq_inc) dq_tap++;
      if (dqs_inc) dqs_tap++;
      if (arm) begin
        since++;
        if (since == 11) rd_data[(LANES-1-cur_lane)*W +: W] = pend;
        if (since == 12) begin rd_data = '0; arm = 0; end
      end
      if (lvl_strobe) begin
        if (step_no == 0 || step_no == TAPS-1)
          chk(dq_tap == step_no && dqs_tap == run_init + step_no,
              "R6 R4 tap positions at strobe", dqs_tap*256 + dq_tap,
              (run_init + step_no)*256 + step_no);
        pend = pass_at(cur_lane, dqs_tap, run_base) ? W'(1 << (step_no % W)) : '0;
        since = 0; arm = 1; step_no++;
      end
    end
  end

  localparam int NV = 4;
  localparam int VEC [NV][2] = '{'{0, 1}, '{3, 0}, '{7, 4}, '{12, 20}};

  task automatic run_scan(input int init, input int base, input bit poke_busy);
    int t;
    @(negedge clk); #1;
    run_init = init; run_base = base;
    settle_cnt = 0; rst_seen = 0; done_cnt = 0; exp_lane = 0; first_rst = 0;
    init_taps = 6'(init); start = 1;
    @(negedge clk); #1; start = 0;
    chk(wl_en && busy, "R2 scan starts", {wl_en, busy}, 3);
    if (poke_busy) begin
      repeat (300) @(negedge clk);
      #1; init_taps = 6'(init + 5); start = 1;
      @(negedge clk); #1; start = 0;
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    #1;
    chk(t < 20000, "R8 done reached", t, 0);
    chk(settle_cnt == 100, "R2 settle cycles", settle_cnt, 100);
    chk(rst_seen == LANES, "R9 R3 lane resets", rst_seen, LANES);
    @(negedge clk); #1;
    chk(!busy && !wl_en && done_cnt == 1, "R8 single done, idle after",
        {busy, wl_en, 4'(done_cnt)}, 1);
    chk(lane_sel == '0, "R3 lane_sel idle", lane_sel, 0);
    for (int n = 0; n < LANES; n++) begin
      logic [TAPS-1:0] e;
      for (int s = 0; s < TAPS; s++) e[s] = pass_at(n, init + s, base);
      res_addr = 2'(n); #1;
      chk(res_data == e, "R5 R7 result bitmap", res_data, e);
    end
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({wl_en, lane_sel, dq_rst, dqs_rst, dq_inc, dqs_inc, lvl_strobe, busy, done} == 0,
        "R1 outputs in reset", {wl_en, lane_sel, busy, done}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!busy && !wl_en, "R1 idle after reset", {busy, wl_en}, 0);
    for (int n = 0; n < LANES; n++) begin
      res_addr = 2'(n); #1;
      chk(res_data == '0, "R1 results cleared", res_data, 0);
    end
    for (int v = 0; v < NV; v++) run_scan(VEC[v][0], VEC[v][1], 1'b0);
    run_scan(2, 2, 1'b1);
    repeat (20) @(negedge clk);
    #1;
    chk(!busy && !lvl_strobe, "R9 no restart", {busy, lvl_strobe}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule